// File: doc/BRIEF.md
# SD Command Response Checker

This block sits behind the command serializer of an SD-style host. The host drives the command and pulses `cmd_sent_i` when it has put the final bit of that command on the CMD line. The block then watches the serial CMD input, which is sampled once per SDCLK. It waits for a response start bit and shifts in the 48-bit short response. It then reports the outcome as a group of one-cycle error pulses together with a one-cycle `done_o`.

The four outcomes checked are these:
- no start bit within the response window;
- a CRC7 mismatch;
- a zero in the end-bit slot;
- an echoed command index that differs from the one sent.

A CMD line conflict means the host is still driving CMD high while it samples a low level. A conflict cuts the command short at once and reports a timeout and a CRC error together. It does not wait for the window to run out. When the command expects no response, the block skips every check and returns `done_o` straight away. Only one command is tracked at a time: a new command is accepted only after `done_o`.

Top module: `sd_rsp_chk`

## Requirements
- R1: After reset is released, every error output and `done_o` are 0, and the block waits in idle for a command.
- R2: `cmd_sent_i` with `rsp_exp_i` = 0 in idle produces `done_o` on the next clock edge, with all error outputs 0.
- R3: After `cmd_sent_i` with `rsp_exp_i` = 1 is accepted, a start bit (0) must come within the next 64 CMD samples. If all 64 samples are 1, `timeout_err_o` and `done_o` pulse on the edge after the 64th sample. A start bit on the 64th sample is accepted.
- R4: A response is the 48 CMD samples that begin with the start bit. `rsp_o` holds them with the first sample at bit 47 and the last at bit 0: bit 46 is the transmission bit, bits 45:40 the index, bits 39:8 the argument, bits 7:1 the CRC and bit 0 the end bit. `rsp_o` and `done_o` are valid on the edge after the 48th sample.
- R5: CRC7 with polynomial x^7+x^3+1 and an all-zero start value is computed over response bits 47:8. If the result differs from bits 7:1, `crc_err_o` pulses with `done_o`.
- R6: If response bit 0 is sampled as 0, `end_err_o` pulses with `done_o`.
- R7: If response bits 45:40 differ from the `cmd_idx_i` latched with the accepted command, `idx_err_o` pulses with `done_o`.
- R8: While waiting for or receiving a response, a CMD sample of 0 with `host_drv_i` = 1 is a conflict. On the next edge `timeout_err_o`, `crc_err_o` and `done_o` pulse together, and the command is abandoned.
- R9: Every output pulse lasts one cycle. An error pulse only appears together with `done_o`.
- R10: `cmd_sent_i` is ignored while a command is in progress. The pending index stays as latched, and no extra `done_o` occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | SDCLK-rate sampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_sent_i | input | 1 | Pulse when the command end bit has been sent |
| cmd_idx_i | input | 6 | Index of the command being sent |
| rsp_exp_i | input | 1 | 1 when the command expects a 48-bit response |
| host_drv_i | input | 1 | Host is driving the CMD line high |
| cmd_i | input | 1 | Sampled CMD line |
| timeout_err_o | output | 1 | No start bit in window, or line conflict |
| crc_err_o | output | 1 | CRC mismatch, or line conflict |
| end_err_o | output | 1 | End bit sampled as 0 |
| idx_err_o | output | 1 | Echoed index differs from sent index |
| done_o | output | 1 | Command finished |
| rsp_o | output | 48 | Captured response, valid with `done_o` |

## Verification
The results of this block arrive at fixed delays after the deciding stimulus:
- `done_o` comes one edge after an accepted `cmd_sent_i` that expects no response.
- The flags and `rsp_o` come one edge after the 48th response sample.
- A timeout comes one edge after the 64th empty sample, which is 65 edges after acceptance.
- A conflict result comes one edge after the conflicting sample.

The bench updates a behavioural model on each rising edge from the same inputs the design sees. It compares every output on the following falling edge, so each expectation is checked in exactly the cycle it is due. Directed summaries of each scenario also confirm which flags appeared with its `done_o`, including the window boundary at sample 64 and conflicts during both waiting and reception.

// File: rtl/sd_rsp_pkg.sv
package sd_rsp_pkg;
  localparam int RSP_W_D    = 48;
  localparam int IDX_W_D    = 6;
  localparam int CRC_W_D    = 7;
  localparam int TO_CYC_D   = 64;
  localparam logic [6:0] CRC_POLY_D = 7'h09;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RECV = 2'd2
  } rsp_st_e;
endpackage

// File: rtl/sd_rsp_crc.sv
module sd_rsp_crc #(
  parameter int           CRC_W = 7,
  parameter logic [CRC_W-1:0] POLY = 7'h09
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             din_i,
  output logic [CRC_W-1:0] crc_o
);
  logic [CRC_W-1:0] crc_q, crc_nxt;
  logic fb;

  assign fb = din_i ^ crc_q[CRC_W-1];

  for (genvar g = 0; g < CRC_W; g++) begin : g_tap
    if (g == 0) begin : g_lsb
      assign crc_nxt[g] = fb & POLY[g];
    end else begin : g_up
      assign crc_nxt[g] = crc_q[g-1] ^ (fb & POLY[g]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= '0;
    else if (clr_i)  crc_q <= '0;
    else if (en_i)   crc_q <= crc_nxt;
  end

  assign crc_o = crc_q;

  // R5
  crc_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (crc_o == '0));

  // R5
  crc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !en_i) |=> $stable(crc_o));
endmodule

// File: rtl/sd_rsp_shift.sv
module sd_rsp_shift #(
  parameter int RSP_W = 48
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             din_i,
  output logic [RSP_W-1:0] q_o
);
  logic [RSP_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sh_q <= '0;
    else if (en_i) sh_q <= {sh_q[RSP_W-2:0], din_i};
  end

  assign q_o = sh_q;

  // R4
  shift_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> (q_o[0] == $past(din_i)));

  // R4
  shift_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(q_o));
endmodule

// File: rtl/sd_rsp_eval.sv
module sd_rsp_eval #(
  parameter int IDX_W = 6,
  parameter int CRC_W = 7
) (
  input  logic [IDX_W-1:0] rx_idx_i,
  input  logic [IDX_W-1:0] exp_idx_i,
  input  logic [CRC_W-1:0] rx_crc_i,
  input  logic [CRC_W-1:0] calc_crc_i,
  input  logic             end_bit_i,
  output logic             idx_bad_o,
  output logic             crc_bad_o,
  output logic             end_bad_o
);
  always_comb begin
    idx_bad_o = (rx_idx_i != exp_idx_i);
    crc_bad_o = (rx_crc_i != calc_crc_i);
    end_bad_o = ~end_bit_i;
  end
endmodule

// File: rtl/sd_rsp_ctrl.sv
module sd_rsp_ctrl
  import sd_rsp_pkg::*;
#(
  parameter int RSP_W    = 48,
  parameter int IDX_W    = 6,
  parameter int CRC_W    = 7,
  parameter int TO_CYC   = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_sent_i,
  input  logic [IDX_W-1:0] cmd_idx_i,
  input  logic             rsp_exp_i,
  input  logic             host_drv_i,
  input  logic             cmd_i,
  input  logic             idx_bad_i,
  input  logic             crc_bad_i,
  input  logic             end_bad_i,
  output logic [IDX_W-1:0] exp_idx_o,
  output logic             shift_en_o,
  output logic             crc_en_o,
  output logic             crc_clr_o,
  output logic             timeout_err_o,
  output logic             crc_err_o,
  output logic             end_err_o,
  output logic             idx_err_o,
  output logic             done_o
);
  localparam int CRC_SPAN = RSP_W - CRC_W - 1;
  localparam int CNT_MAX  = (TO_CYC > RSP_W) ? TO_CYC : RSP_W;
  localparam int CNT_W    = $clog2(CNT_MAX + 1);

  rsp_st_e          st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [IDX_W-1:0] idx_q;
  logic busy, conflict, accept, start, last, to_hit;
  logic done_d, to_d, crc_d, end_d, idx_d;

  always_comb begin
    busy     = (st_q != ST_IDLE);
    conflict = busy && host_drv_i && !cmd_i;
    accept   = (st_q == ST_IDLE) && cmd_sent_i;
    start    = (st_q == ST_WAIT) && !cmd_i && !conflict;
    to_hit   = (st_q == ST_WAIT) && cmd_i && !conflict
               && (cnt_q == CNT_W'(TO_CYC - 1));
    last     = (st_q == ST_RECV) && !conflict
               && (cnt_q == CNT_W'(RSP_W - 1));
  end

  assign shift_en_o = start || ((st_q == ST_RECV) && !conflict);
  assign crc_en_o   = start || ((st_q == ST_RECV) && !conflict
                                && (cnt_q < CNT_W'(CRC_SPAN)));
  assign crc_clr_o  = accept;
  assign exp_idx_o  = idx_q;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      ST_IDLE: begin
        if (accept && rsp_exp_i) begin
          st_d  = ST_WAIT;
          cnt_d = '0;
        end
      end
      ST_WAIT: begin
        if (conflict || to_hit) begin
          st_d = ST_IDLE;
        end else if (start) begin
          st_d  = ST_RECV;
          cnt_d = CNT_W'(1);
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_RECV: begin
        if (conflict || last) st_d = ST_IDLE;
        else                  cnt_d = cnt_q + 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    done_d = (accept && !rsp_exp_i) || conflict || to_hit || last;
    to_d   = conflict || to_hit;
    crc_d  = conflict || (last && crc_bad_i);
    end_d  = last && end_bad_i;
    idx_d  = last && idx_bad_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q          <= ST_IDLE;
      cnt_q         <= '0;
      idx_q         <= '0;
      done_o        <= 1'b0;
      timeout_err_o <= 1'b0;
      crc_err_o     <= 1'b0;
      end_err_o     <= 1'b0;
      idx_err_o     <= 1'b0;
    end else begin
      st_q          <= st_d;
      cnt_q         <= cnt_d;
      if (accept) idx_q <= cmd_idx_i;
      done_o        <= done_d;
      timeout_err_o <= to_d;
      crc_err_o     <= crc_d;
      end_err_o     <= end_d;
      idx_err_o     <= idx_d;
    end
  end

  // R8
  conflict_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && host_drv_i && !cmd_i) |=> (timeout_err_o && crc_err_o && done_o && (st_q == ST_IDLE)));

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R9
  flag_needs_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timeout_err_o || crc_err_o || end_err_o || idx_err_o) |-> done_o);

  // R2
  no_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == ST_IDLE) && cmd_sent_i && !rsp_exp_i)
      |=> (done_o && !timeout_err_o && !crc_err_o && !end_err_o && !idx_err_o));

  // R10
  exp_idx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && cmd_sent_i) |=> $stable(exp_idx_o));

  // R3
  timeout_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timeout_err_o && !crc_err_o) |-> (!end_err_o && !idx_err_o));
endmodule

// File: rtl/sd_rsp_chk.sv
module sd_rsp_chk
  import sd_rsp_pkg::*;
#(
  parameter int RSP_W  = RSP_W_D,
  parameter int IDX_W  = IDX_W_D,
  parameter int CRC_W  = CRC_W_D,
  parameter int TO_CYC = TO_CYC_D,
  parameter logic [CRC_W-1:0] CRC_POLY = CRC_POLY_D
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_sent_i,
  input  logic [IDX_W-1:0] cmd_idx_i,
  input  logic             rsp_exp_i,
  input  logic             host_drv_i,
  input  logic             cmd_i,
  output logic             timeout_err_o,
  output logic             crc_err_o,
  output logic             end_err_o,
  output logic             idx_err_o,
  output logic             done_o,
  output logic [RSP_W-1:0] rsp_o
);
  // Field tops in the shift register one sample before the frame completes
  localparam int CRC_SPAN = RSP_W - CRC_W - 1;
  localparam int IDX_TOP  = RSP_W - 4;
  localparam int CRC_TOP  = RSP_W - 2 - CRC_SPAN;

  logic [RSP_W-1:0] sh_q;
  logic [CRC_W-1:0] calc_crc;
  logic [IDX_W-1:0] exp_idx;
  logic shift_en, crc_en, crc_clr;
  logic idx_bad, crc_bad, end_bad;

  sd_rsp_ctrl #(
    .RSP_W (RSP_W),
    .IDX_W (IDX_W),
    .CRC_W (CRC_W),
    .TO_CYC(TO_CYC)
  ) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_sent_i   (cmd_sent_i),
    .cmd_idx_i    (cmd_idx_i),
    .rsp_exp_i    (rsp_exp_i),
    .host_drv_i   (host_drv_i),
    .cmd_i        (cmd_i),
    .idx_bad_i    (idx_bad),
    .crc_bad_i    (crc_bad),
    .end_bad_i    (end_bad),
    .exp_idx_o    (exp_idx),
    .shift_en_o   (shift_en),
    .crc_en_o     (crc_en),
    .crc_clr_o    (crc_clr),
    .timeout_err_o(timeout_err_o),
    .crc_err_o    (crc_err_o),
    .end_err_o    (end_err_o),
    .idx_err_o    (idx_err_o),
    .done_o       (done_o)
  );

  sd_rsp_shift #(.RSP_W(RSP_W)) u_shift (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (shift_en),
    .din_i (cmd_i),
    .q_o   (sh_q)
  );

  sd_rsp_crc #(.CRC_W(CRC_W), .POLY(CRC_POLY)) u_crc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (crc_clr),
    .en_i  (crc_en),
    .din_i (cmd_i),
    .crc_o (calc_crc)
  );

  sd_rsp_eval #(.IDX_W(IDX_W), .CRC_W(CRC_W)) u_eval (
    .rx_idx_i  (sh_q[IDX_TOP -: IDX_W]),
    .exp_idx_i (exp_idx),
    .rx_crc_i  (sh_q[CRC_TOP -: CRC_W]),
    .calc_crc_i(calc_crc),
    .end_bit_i (cmd_i),
    .idx_bad_o (idx_bad),
    .crc_bad_o (crc_bad),
    .end_bad_o (end_bad)
  );

  assign rsp_o = sh_q;
endmodule

// File: tb/sd_rsp_chk_tb.sv
module sd_rsp_chk_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_sent = 1'b0;
  logic [5:0]  cmd_idx = '0;
  logic        rsp_exp = 1'b0;
  logic        host_drv = 1'b0;
  logic        cmd = 1'b1;
  logic        to_err, crc_err, end_err, idx_err, done;
  logic [47:0] rsp;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #(CLK_P/2) clk = ~clk;

  sd_rsp_chk u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_sent_i(cmd_sent), .cmd_idx_i(cmd_idx),
    .rsp_exp_i(rsp_exp), .host_drv_i(host_drv), .cmd_i(cmd),
    .timeout_err_o(to_err), .crc_err_o(crc_err), .end_err_o(end_err),
    .idx_err_o(idx_err), .done_o(done), .rsp_o(rsp)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [6:0] crc_bits(input logic [47:0] f);
    logic [6:0] c = '0;
    for (int i = 47; i >= 8; i--) begin
      logic fb = f[i] ^ c[6];
      c = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction

  function automatic logic [47:0] mk_frame(input logic [5:0] idx, input logic [31:0] arg);
    logic [47:0] f = {2'b00, idx, arg, 7'h00, 1'b1};
    f[7:1] = crc_bits(f);
    return f;
  endfunction

  // Behavioural reference: state kept as integers and a bit queue
  int   m_st = 0, m_cnt = 0;
  logic [5:0] m_idx = '0;
  bit   q[$];
  logic e_done = 0, e_to = 0, e_crc = 0, e_end = 0, e_idx = 0;
  logic [47:0] e_rsp = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; q.delete();
      e_done = 0; e_to = 0; e_crc = 0; e_end = 0; e_idx = 0;
    end else begin
      cyc++;
      e_done = 0; e_to = 0; e_crc = 0; e_end = 0; e_idx = 0;
      if (m_st != 0 && host_drv && !cmd) begin
        e_done = 1; e_to = 1; e_crc = 1; m_st = 0;
      end else if (m_st == 0) begin
        if (cmd_sent) begin
          if (!rsp_exp) e_done = 1;
          else begin m_st = 1; m_cnt = 0; m_idx = cmd_idx; q.delete(); end
        end
      end else if (m_st == 1) begin
        if (!cmd) begin q.push_back(1'b0); m_st = 2; end
        else begin
          m_cnt++;
          if (m_cnt == 64) begin e_done = 1; e_to = 1; m_st = 0; end
        end
      end else begin
        q.push_back(cmd);
        if (q.size() == 48) begin
          logic [47:0] f;
          for (int i = 0; i < 48; i++) f[47-i] = q[i];
          e_rsp  = f;
          e_done = 1;
          e_end  = (f[0] == 1'b0);
          e_idx  = (f[45:40] != m_idx);
          e_crc  = (crc_bits(f) != f[7:1]);
          m_st   = 0;
        end
      end
    end
  end

  // Per-cycle comparison, away from the rising edge
  int obs_done = 0;
  logic obs_to = 0, obs_crc = 0, obs_end = 0, obs_idx = 0;
  logic [47:0] obs_rsp = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      chk(done == e_done,   "R9 done_o",        done,    e_done);
      chk(to_err == e_to,   "R3 timeout_err_o", to_err,  e_to);
      chk(crc_err == e_crc, "R5 crc_err_o",     crc_err, e_crc);
      chk(end_err == e_end, "R6 end_err_o",     end_err, e_end);
      chk(idx_err == e_idx, "R7 idx_err_o",     idx_err, e_idx);
      if (e_done && !e_to && q.size() == 48)
        chk(rsp == e_rsp, "R4 rsp_o", rsp, e_rsp);
      if (done) begin
        obs_done++;
        obs_to |= to_err; obs_crc |= crc_err; obs_end |= end_err; obs_idx |= idx_err;
        obs_rsp = rsp;
      end
    end
  end

  task automatic clr_obs();
    obs_done = 0; obs_to = 0; obs_crc = 0; obs_end = 0; obs_idx = 0;
  endtask

  task automatic step(input logic c, input logic hd, input logic sent);
    @(negedge clk); #1;
    cmd = c; host_drv = hd; cmd_sent = sent;
  endtask

  task automatic issue(input logic [5:0] idx, input logic exp);
    @(negedge clk); #1;
    cmd_sent = 1'b1; cmd_idx = idx; rsp_exp = exp; host_drv = 1'b1; cmd = 1'b1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 1'b0);
  endtask

  task automatic send(input logic [47:0] f);
    for (int i = 47; i >= 0; i--) step(f[i], 1'b0, 1'b0);
  endtask

  task automatic expect_obs(input string tag, input logic t, input logic c,
                            input logic e, input logic x);
    chk(obs_done == 1, {tag, " done count"}, obs_done, 1);
    chk({obs_to, obs_crc, obs_end, obs_idx} == {t, c, e, x}, {tag, " flags"},
        {obs_to, obs_crc, obs_end, obs_idx}, {t, c, e, x});
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=%0d exp=done", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : stim
    logic [47:0] f;
    repeat (3) @(negedge clk);
    // R1: outputs quiet before and just after reset release
    chk({to_err, crc_err, end_err, idx_err, done} == 5'b0, "R1 reset outputs",
        {to_err, crc_err, end_err, idx_err, done}, 0);
    #1 rst_n = 1'b1;
    idle(4);
    chk({to_err, crc_err, end_err, idx_err, done} == 5'b0, "R1 idle outputs",
        {to_err, crc_err, end_err, idx_err, done}, 0);

    // R2: no response expected
    clr_obs(); issue(6'd0, 1'b0); idle(3);
    expect_obs("R2 no-rsp", 0, 0, 0, 0);

    // R4: clean response after a short gap
    clr_obs(); f = mk_frame(6'd17, 32'h1234_ABCD);
    issue(6'd17, 1'b1); idle(5); send(f); idle(3);
    expect_obs("R4 good", 0, 0, 0, 0);
    chk(obs_rsp == f, "R4 captured frame", obs_rsp, f);

    // R4: response starting on the first sample
    clr_obs(); f = mk_frame(6'd63, 32'hFFFF_0000);
    issue(6'd63, 1'b1); send(f); idle(3);
    expect_obs("R4 zero-gap", 0, 0, 0, 0);

    // R5: corrupted CRC
    clr_obs(); f = mk_frame(6'd8, 32'h0000_0001); f[3] = ~f[3];
    issue(6'd8, 1'b1); idle(2); send(f); idle(3);
    expect_obs("R5 bad crc", 0, 1, 0, 0);

    // R6: end bit low
    clr_obs(); f = mk_frame(6'd2, 32'hA5A5_5A5A); f[0] = 1'b0;
    issue(6'd2, 1'b1); idle(1); send(f); idle(3);
    expect_obs("R6 bad end", 0, 0, 1, 0);

    // R7: index differs from the sent one
    clr_obs(); f = mk_frame(6'd41, 32'hDEAD_BEEF);
    issue(6'd40, 1'b1); idle(1); send(f); idle(3);
    expect_obs("R7 bad idx", 0, 0, 0, 1);

    // R5 R6 R7 together
    clr_obs(); f = mk_frame(6'd9, 32'h0F0F_0F0F); f[5] = ~f[5]; f[0] = 1'b0;
    issue(6'd10, 1'b1); send(f); idle(3);
    expect_obs("R5 R6 R7 combined", 0, 1, 1, 1);

    // R3: no start bit at all
    clr_obs(); issue(6'd3, 1'b1); idle(70);
    expect_obs("R3 timeout", 1, 0, 0, 0);

    // R3: start bit on the 64th sample is still accepted
    clr_obs(); f = mk_frame(6'd5, 32'h8000_0001);
    issue(6'd5, 1'b1); idle(63); send(f); idle(3);
    expect_obs("R3 boundary", 0, 0, 0, 0);

    // R8: conflict while waiting
    clr_obs(); issue(6'd7, 1'b1); idle(10); step(1'b0, 1'b1, 1'b0); idle(3);
    expect_obs("R8 conflict wait", 1, 1, 0, 0);

    // R8: conflict during reception, rest of frame ignored afterwards
    clr_obs(); f = mk_frame(6'd7, 32'h1357_9BDF);
    issue(6'd7, 1'b1); idle(2);
    for (int i = 47; i >= 30; i--) step(f[i], 1'b0, 1'b0);
    step(1'b0, 1'b1, 1'b0);
    idle(3);
    expect_obs("R8 conflict recv", 1, 1, 0, 0);

    // R10: second cmd_sent while waiting is ignored
    clr_obs(); f = mk_frame(6'd21, 32'h2468_ACE0);
    issue(6'd21, 1'b1); idle(3);
    @(negedge clk); #1; cmd_sent = 1'b1; cmd_idx = 6'd22; rsp_exp = 1'b0; host_drv = 1'b0; cmd = 1'b1;
    idle(2); send(f); idle(3);
    expect_obs("R10 busy ignore", 0, 0, 0, 0);

    // R9: done stays single-cycle; confirm quiet after run
    idle(5);
    chk(done == 1'b0, "R9 quiet after", done, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule